// File: doc/BRIEF.md
# Serial Field-Memory Read Port

This block is the read half of a dual-clock serial field memory. It owns a read address pointer that walks a behavioural storage array one word per enabled read-clock edge, and it presents the addressed word on a registered data output. A rewind request sends the pointer back to the first word of the array. A read-enable gates pointer movement. A separate output-enable only hides the output, so words can be skipped while the pointer keeps moving.

The three-state output pins are modelled as a data bus plus a drive-enable flag (`dout_valid`). The shared array appears here as a plain addressed write port clocked by the read clock. That port only exists so the array can be loaded. Two single-cycle flags report usage errors: a rewind that follows too few active reads, and a rewind that follows the previous one too closely.

Top module: `fpr_read_port`

## Requirements
- R1: On a rising clock edge that samples `rewind` high, `rd_ptr` becomes 0 and `dout` presents the word stored at address 0 with `dout_valid` high.
- R2: In a rewind cycle the levels of `rd_en` and `out_en` have no effect on the pointer, the data or `dout_valid`.
- R3: On an edge with `rewind` low and `rd_en` high, `rd_ptr` advances by one and `dout` presents the word at the new address.
- R4: On an edge with `rewind` low and `rd_en` low, `rd_ptr`, `dout` and `dout_valid` all keep their values, whatever `out_en` is.
- R5: On an edge with `rewind` low, `rd_en` high and `out_en` low, `dout_valid` goes low but the pointer still advances. When the output is enabled again, it shows the word at the advanced address, so the words in between are skipped.
- R6: `dout` equals the stored word bit for bit, with no inversion.
- R7: `rewind_too_soon` pulses for one cycle after a new rewind whose request was low on only one edge since the previous rewind. `MIN_GAP` is 2. Edges where `rewind` stays high are reset cycles but do not count as new rewinds.
- R8: `short_burst` pulses for one cycle after a new rewind (not the first since reset) when fewer than `MIN_BURST` (80) advancing edges occurred since the previous new rewind. With exactly 80 it stays low.
- R9: An advance from address `DEPTH-1` wraps `rd_ptr` to 0.
- R10: While `rst` is high, `rd_ptr`, `dout`, `dout_valid` and both flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| rewind | input | 1 | Pointer rewind request |
| rd_en | input | 1 | Read enable, gates pointer movement |
| out_en | input | 1 | Output enable, gates the output drive only |
| mem_we | input | 1 | Array load strobe |
| mem_waddr | input | 10 | Array load address |
| mem_wdata | input | 8 | Array load data |
| dout | output | 8 | Registered read data |
| dout_valid | output | 1 | Output drive enable (low models high impedance) |
| rd_ptr | output | 10 | Address of the word currently presented |
| short_burst | output | 1 | Rewind after too few active reads |
| rewind_too_soon | output | 1 | Rewind with too short a low gap |

## Verification
The array is loaded with an address-scrambled pattern, so each presented word identifies the address it came from. A vector table interleaves advance, hold, blanked-advance and rewind cycles. A skipped word is told apart from a held word because the data after re-enabling must come from the advanced address. Rewinds issued with `rd_en` and `out_en` at both levels show that those inputs are ignored. A long walk through every address tests the wrap. Bursts of 79 and 80 reads before a rewind, and a rewind after a one-edge gap and after a held request, separate the two error flags from one another and from their boundaries.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;

    typedef struct packed {
        logic rewind;
        logic rd_en;
        logic out_en;
    } rd_ctrl_t;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_ADV    = 2'd1,
        STEP_REWIND = 2'd2
    } step_e;

    // Rewind dominates; enables matter only outside a rewind cycle.
    function automatic step_e classify(input rd_ctrl_t c);
        if (c.rewind)     return STEP_REWIND;
        else if (c.rd_en) return STEP_ADV;
        else              return STEP_HOLD;
    endfunction

endpackage

// File: rtl/fpr_array.sv
`timescale 1ns/1ps
module fpr_array #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fpr_pointer.sv
`timescale 1ns/1ps
module fpr_pointer
    import fpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  logic              out_en,
    input  logic [DATA_W-1:0] rdata,
    output logic [AW-1:0]     next_addr,
    output logic [AW-1:0]     ptr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_comb begin
        unique case (step)
            STEP_REWIND: next_addr = '0;
            STEP_ADV:    next_addr = (ptr == LAST) ? '0 : ptr + 1'b1;
            default:     next_addr = ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            ptr <= next_addr;
            if (step != STEP_HOLD) dout <= rdata;
            if (step == STEP_REWIND)   dout_valid <= 1'b1;
            else if (step == STEP_ADV) dout_valid <= out_en;
        end
    end

    assert_rewind_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_REWIND) |=> (ptr == '0) && dout_valid);

    assert_hold_state_R4: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_HOLD) |=> $stable(ptr) && $stable(dout) && $stable(dout_valid));

    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_ADV && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_ADV && ptr == LAST) |=> ptr == '0);

    assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_ADV && !out_en) |=> !dout_valid);
endmodule

// File: rtl/fpr_seq_check.sv
`timescale 1ns/1ps
module fpr_seq_check
    import fpr_pkg::*;
#(
    parameter int MIN_BURST = 80,
    parameter int MIN_GAP   = 2,
    localparam int BW       = $clog2(MIN_BURST + 1),
    localparam int GW       = $clog2(MIN_GAP + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rewind,
    input  step_e step,
    output logic  short_burst,
    output logic  rewind_too_soon
);
    localparam logic [BW-1:0] BURST_SAT = BW'(MIN_BURST);
    localparam logic [GW-1:0] GAP_SAT   = GW'(MIN_GAP);

    logic [BW-1:0] burst_cnt;
    logic [GW-1:0] gap_cnt;
    logic          armed;
    logic          fresh;

    // A request counts as new only if it was low on the previous edge.
    assign fresh = rewind && (gap_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_cnt       <= '0;
            gap_cnt         <= GAP_SAT;
            armed           <= 1'b0;
            short_burst     <= 1'b0;
            rewind_too_soon <= 1'b0;
        end else begin
            short_burst     <= fresh && armed && (burst_cnt < BURST_SAT);
            rewind_too_soon <= fresh && (gap_cnt < GAP_SAT);
            if (rewind)                gap_cnt <= '0;
            else if (gap_cnt < GAP_SAT) gap_cnt <= gap_cnt + 1'b1;
            if (fresh) begin
                burst_cnt <= '0;
                armed     <= 1'b1;
            end else if (step == STEP_ADV && burst_cnt < BURST_SAT) begin
                burst_cnt <= burst_cnt + 1'b1;
            end
        end
    end

    assert_flags_follow_rewind_R7: assert property (@(posedge clk) disable iff (rst)
        (short_burst || rewind_too_soon) |-> $past(rewind));

    assert_held_request_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (rewind && $past(rewind)) |=> !short_burst && !rewind_too_soon);
endmodule

// File: rtl/fpr_read_port.sv
`timescale 1ns/1ps
module fpr_read_port
    import fpr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 1024,
    parameter int MIN_BURST = 80,
    parameter int MIN_GAP   = 2,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rewind,
    input  logic              rd_en,
    input  logic              out_en,
    input  logic              mem_we,
    input  logic [AW-1:0]     mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic [AW-1:0]     rd_ptr,
    output logic              short_burst,
    output logic              rewind_too_soon
);
    rd_ctrl_t          ctrl;
    step_e             step;
    logic [AW-1:0]     next_addr;
    logic [DATA_W-1:0] rdata;

    assign ctrl = '{rewind: rewind, rd_en: rd_en, out_en: out_en};
    assign step = classify(ctrl);

    fpr_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) array_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (next_addr),
        .rdata (rdata)
    );

    fpr_pointer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) pointer_i (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .out_en     (ctrl.out_en),
        .rdata      (rdata),
        .next_addr  (next_addr),
        .ptr        (rd_ptr),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    fpr_seq_check #(.MIN_BURST(MIN_BURST), .MIN_GAP(MIN_GAP)) seq_i (
        .clk             (clk),
        .rst             (rst),
        .rewind          (ctrl.rewind),
        .step            (step),
        .short_burst     (short_burst),
        .rewind_too_soon (rewind_too_soon)
    );

    assert_rewind_ignores_enables_R2: assert property (@(posedge clk) disable iff (rst)
        rewind |=> dout_valid && rd_ptr == '0);
endmodule

// File: tb/fpr_read_port_tb.sv
`timescale 1ns/1ps
module fpr_read_port_tb_top;
    localparam int DEPTH = 1024;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rewind = 1'b0, rd_en = 1'b0, out_en = 1'b0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    dout;
    logic          dout_valid, short_burst, rewind_too_soon;
    logic [AW-1:0] rd_ptr;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fpr_read_port dut_i (
        .clk(clk), .rst(rst), .rewind(rewind), .rd_en(rd_en), .out_en(out_en),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .dout(dout), .dout_valid(dout_valid), .rd_ptr(rd_ptr),
        .short_burst(short_burst), .rewind_too_soon(rewind_too_soon)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) ^ (a >> 2));
    endfunction

    typedef struct packed {
        logic          rw, re, oe;
        logic          ev;
        logic [AW-1:0] ea;
        logic          es, et;
    } vec_t;

    // rewind, rd_en, out_en | valid, pointer, short flag, soon flag
    localparam vec_t VECS [13] = '{
        '{1'b1,1'b0,1'b1, 1'b1,10'd0, 1'b0,1'b0},  // R1 first rewind
        '{1'b0,1'b1,1'b1, 1'b1,10'd1, 1'b0,1'b0},  // R3
        '{1'b0,1'b1,1'b1, 1'b1,10'd2, 1'b0,1'b0},  // R3
        '{1'b0,1'b0,1'b1, 1'b1,10'd2, 1'b0,1'b0},  // R4 hold
        '{1'b0,1'b0,1'b0, 1'b1,10'd2, 1'b0,1'b0},  // R4 hold, out_en ignored
        '{1'b0,1'b1,1'b0, 1'b0,10'd3, 1'b0,1'b0},  // R5 blanked advance
        '{1'b0,1'b1,1'b0, 1'b0,10'd4, 1'b0,1'b0},  // R5
        '{1'b0,1'b1,1'b1, 1'b1,10'd5, 1'b0,1'b0},  // R5 skipped to 5
        '{1'b1,1'b0,1'b0, 1'b1,10'd0, 1'b1,1'b0},  // R2 R8 rewind, short
        '{1'b0,1'b1,1'b1, 1'b1,10'd1, 1'b0,1'b0},  // R3
        '{1'b1,1'b1,1'b1, 1'b1,10'd0, 1'b1,1'b1},  // R2 R7 gap of one
        '{1'b1,1'b1,1'b0, 1'b1,10'd0, 1'b0,1'b0},  // R7 held request quiet
        '{1'b0,1'b1,1'b1, 1'b1,10'd1, 1'b0,1'b0}   // R3
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic rw, input logic re, input logic oe);
        rewind = rw; rd_en = re; out_en = oe;
        @(negedge clk);
    endtask

    task automatic check_word(input string req, input int addr);
        chk(req, "rd_ptr", int'(rd_ptr), addr);
        chk(req, "dout", int'(dout), int'(pat(addr)));
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        // R10 reset state
        chk("R10", "rd_ptr", int'(rd_ptr), 0);
        chk("R10", "dout", int'(dout), 0);
        chk("R10", "dout_valid", int'(dout_valid), 0);
        chk("R10", "flags", int'({short_burst, rewind_too_soon}), 0);
        rst = 1'b0;

        for (int a = 0; a < DEPTH; a++) begin
            mem_we = 1'b1; mem_waddr = AW'(a); mem_wdata = pat(a);
            @(negedge clk);
        end
        mem_we = 1'b0;
        chk("R4", "rd_ptr after load", int'(rd_ptr), 0);

        for (int i = 0; i < 13; i++) begin
            drive(VECS[i].rw, VECS[i].re, VECS[i].oe);
            chk("R5", "dout_valid", int'(dout_valid), int'(VECS[i].ev));
            chk("R3", "rd_ptr", int'(rd_ptr), int'(VECS[i].ea));
            if (VECS[i].ev)
                chk("R6", "dout", int'(dout), int'(pat(int'(VECS[i].ea))));
            chk("R8", "short_burst", int'(short_burst), int'(VECS[i].es));
            chk("R7", "rewind_too_soon", int'(rewind_too_soon), int'(VECS[i].et));
        end

        // R9 walk the whole array and wrap
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b1, 1'b0, 1'b0);
        check_word("R1", 0);
        for (int a = 1; a < DEPTH; a++) begin
            drive(1'b0, 1'b1, 1'b1);
            check_word("R6", a);
        end
        drive(1'b0, 1'b1, 1'b1);
        check_word("R9", 0);
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
        chk("R8", "short_burst after long run", int'(short_burst), 0);
        chk("R7", "rewind_too_soon after long run", int'(rewind_too_soon), 0);

        // R8 boundary: 79 reads is short
        for (int i = 0; i < 79; i++) drive(1'b0, 1'b1, 1'b1);
        check_word("R3", 79);
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b1, 1'b0, 1'b1);
        chk("R8", "short_burst at 79", int'(short_burst), 1);

        // R8 boundary: 80 reads is enough
        for (int i = 0; i < 80; i++) drive(1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b1, 1'b0, 1'b1);
        chk("R8", "short_burst at 80", int'(short_burst), 0);
        check_word("R1", 0);
        drive(1'b0, 1'b0, 1'b1);
        chk("R8", "short_burst pulse width", int'(short_burst), 0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            nbad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule